// File: doc/BRIEF.md
# Battery Over-Current Burst Controller

The controller compares each digitised battery-current sample, delivered as a word with a valid strobe, against two programmable limits. While samples stay above the warning limit, one elapsed-time counter runs in microsecond ticks. Three comparators read that counter, one for each of three programmable durations. The first duration raises an interrupt. The second raises an interrupt and throttles high-current subsystems through masked action outputs. The third requests shutdown. A sample above the shutdown limit requests shutdown on the next cycle, without waiting for any timer.

Every action that is taken leaves a sticky bit in a status register. Software clears those bits by writing the register back. A byte-wide register port holds the following:
- the limit codes;
- the duration codes;
- the action mask;
- the unit enable and the system-burst action enable;
- the status register.

A parameterised prescaler derives the microsecond tick from the system clock.

Register addresses:
- 0: limits
- 1: first and second durations
- 2: third duration
- 3: action mask
- 4: configuration
- 5: status

Top module: `ocd_burst_ctrl`

## Requirements
- R1: Warning limit code is field [2:0] of address 0. Codes 0..7 select 1400, 1800, 2200, 2800, 3000, 3400, 3800 and 4800 mA. A valid sample strictly above the limit starts the duration timers. A sample equal to the limit does not start them.
- R2: Shutdown limit code is field [5:3] of address 0. Codes 0..7 select 1800, 2200, 2800, 3000, 3800, 4800, 5800 and 5800 mA. shutdown_req_o is high in the cycle after a valid sample above this limit is captured. It falls after a sample at or below the limit, provided status bit 7 is clear.
- R3: The first duration is field [3:0] of address 1 and lasts 200 + 500*code µs. When it expires, status bit 5 and irq_o are set. If mask bit 4 is set, status bit 4 and camera_o are also set.
- R4: The second duration is field [7:4] of address 1 and lasts 200 + 500*code µs. When it expires, status bit 6 and irq_o are set. Status bits 0, 1 and 2 (audio crush, vibra disable, SoC burst disable) are set when their mask bits are set. Status bit 3 (system burst disable) is set only when mask bit 3 and configuration bit 3 are both set. Each action output follows its status bit.
- R5: The third duration is field [3:0] of address 2. It lasts 1000*code µs, and code 0 means 200 µs. When it expires, status bit 7 and shutdown_req_o are set.
- R6: All three durations are counted from the same capture of an above-warning sample. Each expiry is seen within one tick of nominal: between (N-1)*TICK_DIV+1 and N*TICK_DIV+3 cycles after capture, for N µs.
- R7: A valid sample at or below the warning limit clears all timers. A later crossing then needs the full duration again.
- R8: Writing address 5 clears each status bit written as 0 and keeps each bit written as 1. A write never sets a bit. irq_o is high exactly while status bit 5 or bit 6 is set.
- R9: The action mask at address 3 resets to 0x08, and its bits [7:5] read as 0. A clear mask bit suppresses its action and its status bit.
- R10: Configuration at address 4 resets to 0x08. While bit 7 is set the unit is disabled: no timing, no new status, and the action and shutdown outputs are low. Clearing bit 7 restores the outputs from the status bits.
- R11: After reset, address 0 reads 0x24 and addresses 1, 2 and 5 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Current sample strobe |
| smp_ma_i | input | CUR_W | Battery current sample in mA |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt, high while a timer flag is set |
| audio_crush_o | output | 1 | Audio volume crush action |
| vibra_dis_o | output | 1 | Vibrator disable action |
| soc_burst_dis_o | output | 1 | SoC burst disable action |
| sys_burst_dis_o | output | 1 | System burst disable action |
| camera_o | output | 1 | Camera throttle action |
| shutdown_req_o | output | 1 | Shutdown request |

## Verification
The immediate-shutdown assertion assumes that no register write lands in the same cycle as a valid sample, because a write could disable the unit in that cycle. The bench therefore keeps writes and sample strobes on separate cycles. The status and timer assertions take expiry events as the only source of new status bits. The stimulus holds a sample level between strobes, so each over-limit episode is a single stretch of time. The bench also clears the timers with a low sample before it clears status, so that no expiry overlaps a write-back.

// File: rtl/ocd_pkg.sv
package ocd_pkg;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned T_MAX_US = 15000;
  localparam int unsigned CNT_W    = $clog2(T_MAX_US + 1);
  localparam int unsigned N_TMR    = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_LIMIT  = 3'd0,
    ADDR_TIME12 = 3'd1,
    ADDR_TIME3  = 3'd2,
    ADDR_MASK   = 3'd3,
    ADDR_CFG    = 3'd4,
    ADDR_STAT   = 3'd5
  } reg_addr_e;

  localparam int unsigned B_AUDIO = 0;
  localparam int unsigned B_VIBRA = 1;
  localparam int unsigned B_SOC   = 2;
  localparam int unsigned B_SYS   = 3;
  localparam int unsigned B_CAM   = 4;
  localparam int unsigned ST_T1   = 5;
  localparam int unsigned ST_T2   = 6;
  localparam int unsigned ST_T3   = 7;

  function automatic int unsigned warn_ma(input logic [2:0] c);
    case (c)
      3'd0: return 1400;
      3'd1: return 1800;
      3'd2: return 2200;
      3'd3: return 2800;
      3'd4: return 3000;
      3'd5: return 3400;
      3'd6: return 3800;
      default: return 4800;
    endcase
  endfunction

  function automatic int unsigned shut_ma(input logic [2:0] c);
    case (c)
      3'd0: return 1800;
      3'd1: return 2200;
      3'd2: return 2800;
      3'd3: return 3000;
      3'd4: return 3800;
      3'd5: return 4800;
      default: return 5800;
    endcase
  endfunction

  function automatic int unsigned t12_us(input logic [3:0] c);
    return 32'd200 + 32'd500 * {28'd0, c};
  endfunction

  function automatic int unsigned t3_us(input logic [3:0] c);
    return (c == 4'd0) ? 32'd200 : 32'd1000 * {28'd0, c};
  endfunction
endpackage

// File: rtl/ocd_tick_gen.sv
module ocd_tick_gen #(
  parameter int unsigned DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  // R6
  tick_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cnt_q} < (CW+1)'(DIV));

  generate
    if (DIV > 1) begin : g_gap
      // R6
      tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/ocd_over_timer.sv
module ocd_over_timer #(
  parameter int unsigned CW   = 14,
  parameter int unsigned NT   = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   run_i,
  input  logic                   tick_i,
  input  logic [NT-1:0][CW-1:0]  thr_i,
  output logic [NT-1:0]          expire_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] elapsed_q;
  logic [NT-1:0] fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elapsed_q <= '0;
      fired_q   <= '0;
    end else if (!run_i) begin
      elapsed_q <= '0;
      fired_q   <= '0;
    end else begin
      if (tick_i && elapsed_q != CNT_MAX) elapsed_q <= elapsed_q + 1'b1;
      fired_q <= fired_q | expire_o;
    end
  end

  generate
    for (genvar i = 0; i < NT; i++) begin : g_cmp
      assign expire_o[i] = run_i & ~fired_q[i] & (elapsed_q >= thr_i[i]);

      // R6
      expire_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o[i] |=> !expire_o[i]);
    end
  endgenerate

  // R7
  elapsed_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> (elapsed_q >= $past(elapsed_q)));
endmodule

// File: rtl/ocd_regs.sv
module ocd_regs
  import ocd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [N_TMR-1:0]  expire_i,
  output logic [2:0]        warn_code_o,
  output logic [2:0]        shut_code_o,
  output logic [3:0]        t1_code_o,
  output logic [3:0]        t2_code_o,
  output logic [3:0]        t3_code_o,
  output logic              unit_en_o,
  output logic [REG_W-1:0]  status_o
);
  logic [5:0]       lim_q;
  logic [7:0]       t12_q;
  logic [3:0]       t3_q;
  logic [4:0]       mask_q;
  logic             dis_q, sys_act_q;
  logic [REG_W-1:0] status_q, status_n;

  always_comb begin
    status_n = status_q;
    if (we_i && addr_i == ADDR_STAT) status_n = status_q & wdata_i;
    if (expire_i[0]) begin
      status_n[ST_T1] = 1'b1;
      if (mask_q[B_CAM]) status_n[B_CAM] = 1'b1;
    end
    if (expire_i[1]) begin
      status_n[ST_T2] = 1'b1;
      if (mask_q[B_AUDIO]) status_n[B_AUDIO] = 1'b1;
      if (mask_q[B_VIBRA]) status_n[B_VIBRA] = 1'b1;
      if (mask_q[B_SOC])   status_n[B_SOC]   = 1'b1;
      if (mask_q[B_SYS] && sys_act_q) status_n[B_SYS] = 1'b1;
    end
    if (expire_i[2]) status_n[ST_T3] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q     <= 6'b100_100;
      t12_q     <= '0;
      t3_q      <= '0;
      mask_q    <= 5'b01000;
      dis_q     <= 1'b0;
      sys_act_q <= 1'b1;
      status_q  <= '0;
    end else begin
      if (we_i) begin
        case (addr_i)
          ADDR_LIMIT:  lim_q  <= wdata_i[5:0];
          ADDR_TIME12: t12_q  <= wdata_i;
          ADDR_TIME3:  t3_q   <= wdata_i[3:0];
          ADDR_MASK:   mask_q <= wdata_i[4:0];
          ADDR_CFG: begin
            dis_q     <= wdata_i[7];
            sys_act_q <= wdata_i[3];
          end
          default: ;
        endcase
      end
      status_q <= status_n;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_LIMIT:  rdata_o = {2'b00, lim_q};
      ADDR_TIME12: rdata_o = t12_q;
      ADDR_TIME3:  rdata_o = {4'h0, t3_q};
      ADDR_MASK:   rdata_o = {3'b000, mask_q};
      ADDR_CFG:    rdata_o = {dis_q, 3'b000, sys_act_q, 3'b000};
      ADDR_STAT:   rdata_o = status_q;
      default:     rdata_o = '0;
    endcase
  end

  assign warn_code_o = lim_q[2:0];
  assign shut_code_o = lim_q[5:3];
  assign t1_code_o   = t12_q[3:0];
  assign t2_code_o   = t12_q[7:4];
  assign t3_code_o   = t3_q;
  assign unit_en_o   = ~dis_q;
  assign status_o    = status_q;

  // R8
  no_spont_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i == '0) |=> ((status_q & ~$past(status_q)) == '0));

  // R3
  t1_flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q[ST_T1]) |-> $past(expire_i[0]));

  // R5
  t3_flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q[ST_T3]) |-> $past(expire_i[2]));
endmodule

// File: rtl/ocd_burst_ctrl.sv
module ocd_burst_ctrl
  import ocd_pkg::*;
#(
  parameter int unsigned CUR_W    = 13,
  parameter int unsigned TICK_DIV = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [CUR_W-1:0]  smp_ma_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o,
  output logic              audio_crush_o,
  output logic              vibra_dis_o,
  output logic              soc_burst_dis_o,
  output logic              sys_burst_dis_o,
  output logic              camera_o,
  output logic              shutdown_req_o
);
  logic [2:0]                   warn_code, shut_code;
  logic [3:0]                   t1_code, t2_code, t3_code;
  logic                         unit_en, tick;
  logic [REG_W-1:0]             status;
  logic [N_TMR-1:0]             expire;
  logic [N_TMR-1:0][CNT_W-1:0]  thr;
  logic [CUR_W-1:0]             warn_lim, shut_lim;
  logic                         over_q, shut_q;

  ocd_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .expire_i    (expire),
    .warn_code_o (warn_code),
    .shut_code_o (shut_code),
    .t1_code_o   (t1_code),
    .t2_code_o   (t2_code),
    .t3_code_o   (t3_code),
    .unit_en_o   (unit_en),
    .status_o    (status)
  );

  ocd_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  assign warn_lim = CUR_W'(warn_ma(warn_code));
  assign shut_lim = CUR_W'(shut_ma(shut_code));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      over_q <= 1'b0;
      shut_q <= 1'b0;
    end else if (!unit_en) begin
      over_q <= 1'b0;
      shut_q <= 1'b0;
    end else if (smp_valid_i) begin
      over_q <= smp_ma_i > warn_lim;
      shut_q <= smp_ma_i > shut_lim;
    end
  end

  assign thr[0] = CNT_W'(t12_us(t1_code));
  assign thr[1] = CNT_W'(t12_us(t2_code));
  assign thr[2] = CNT_W'(t3_us(t3_code));

  ocd_over_timer #(.CW(CNT_W), .NT(N_TMR)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (over_q & unit_en),
    .tick_i   (tick),
    .thr_i    (thr),
    .expire_o (expire)
  );

  assign irq_o           = status[ST_T1] | status[ST_T2];
  assign audio_crush_o   = unit_en & status[B_AUDIO];
  assign vibra_dis_o     = unit_en & status[B_VIBRA];
  assign soc_burst_dis_o = unit_en & status[B_SOC];
  assign sys_burst_dis_o = unit_en & status[B_SYS];
  assign camera_o        = unit_en & status[B_CAM];
  assign shutdown_req_o  = unit_en & (status[ST_T3] | shut_q);

  // R2
  shut_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && unit_en && !reg_we_i && smp_ma_i > shut_lim) |=> shutdown_req_o);

  // R10
  dis_no_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unit_en |-> (expire == '0));

  // R1
  warn_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && smp_ma_i <= warn_lim) |=> (expire == '0));
endmodule

// File: tb/ocd_burst_ctrl_test.sv
module ocd_burst_ctrl_test;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        smp_valid = 1'b0;
  logic [12:0] smp_ma = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd5;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq, aud, vib, soc, sys, cam, shut;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  ocd_burst_ctrl #(.CUR_W(13), .TICK_DIV(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .smp_valid_i(smp_valid), .smp_ma_i(smp_ma),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .audio_crush_o(aud), .vibra_dis_o(vib), .soc_burst_dis_o(soc),
    .sys_burst_dis_o(sys), .camera_o(cam), .shutdown_req_o(shut)
  );

  function automatic int wlim(input int c);
    case (c)
      0: return 1400; 1: return 1800; 2: return 2200; 3: return 2800;
      4: return 3000; 5: return 3400; 6: return 3800; default: return 4800;
    endcase
  endfunction

  function automatic int slim(input int c);
    case (c)
      0: return 1800; 1: return 2200; 2: return 2800; 3: return 3000;
      4: return 3800; 5: return 4800; default: return 5800;
    endcase
  endfunction

  function automatic int d12(input int c); return 200 + 500 * c; endfunction
  function automatic int d3(input int c);  return (c == 0) ? 200 : 1000 * c; endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_win(input string req, input int act, input int n_us);
    int lo, hi;
    lo = (n_us - 1) * DIV + 1;
    hi = n_us * DIV + 3;
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 3'd5;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk);
    addr = a;
    #1 d = int'(rdata);
    addr = 3'd5;
  endtask

  task automatic send(input int v);
    @(negedge clk);
    smp_valid = 1'b1; smp_ma = 13'(v);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic episode(input int maxc, output int c5, output int c6, output int c7);
    c5 = 0; c6 = 0; c7 = 0;
    for (int i = 1; i <= maxc; i++) begin
      if (c5 == 0 && rdata[5]) c5 = i;
      if (c6 == 0 && rdata[6]) c6 = i;
      if (c7 == 0 && rdata[7]) c7 = i;
      @(negedge clk);
    end
  endtask

  task automatic quiesce();
    send(0);
    wr(3'd5, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d, c5, c6, c7;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R11 / R9 / R10 reset values
    rd(3'd0, d); chk("R11 limit reset", d, 8'h24);
    rd(3'd1, d); chk("R11 time12 reset", d, 0);
    rd(3'd2, d); chk("R11 time3 reset", d, 0);
    rd(3'd5, d); chk("R11 status reset", d, 0);
    rd(3'd3, d); chk("R9 mask reset", d, 8'h08);
    rd(3'd4, d); chk("R10 cfg reset", d, 8'h08);
    chk("R11 irq reset", int'(irq), 0);
    chk("R11 shutdown reset", int'(shut), 0);

    // R9 reserved mask bits
    wr(3'd3, 8'hFF); rd(3'd3, d); chk("R9 mask reserved", d, 8'h1F);

    // R1 warning limit sweep (T1=T2=200us, T3=200us)
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    for (int c = 0; c < 8; c++) begin
      wr(3'd0, 8'(8'h38 | c));
      send(wlim(c));
      episode(d12(0) * DIV + 100, c5, c6, c7);
      chk($sformatf("R1 at limit code %0d no flag", c), c5, 0);
      send(wlim(c) + 1);
      episode(d12(0) * DIV + 20, c5, c6, c7);
      chk_win($sformatf("R1 above limit code %0d T1", c), c5, d12(0));
      if (c == 0) chk_win("R5 T3 code 0", c7, d3(0));
      quiesce();
    end

    // R2 shutdown limit sweep
    for (int c = 0; c < 8; c++) begin
      wr(3'd0, 8'(8'h07 | (c << 3)));
      send(slim(c) + 1);
      chk($sformatf("R2 above shut code %0d", c), int'(shut), 1);
      send(slim(c));
      chk($sformatf("R2 at shut code %0d", c), int'(shut), 0);
      send(0);
    end
    wr(3'd5, 8'h00);

    // R3 R4 R5 R6 duration episodes, all actions enabled
    wr(3'd0, 8'h24); wr(3'd3, 8'h1F); wr(3'd4, 8'h08);
    for (int e = 0; e < 3; e++) begin
      int a1, a2, a3, mx;
      a1 = (e == 0) ? 0 : (e == 1) ? 2 : 1;
      a2 = (e == 0) ? 1 : (e == 1) ? 0 : 3;
      a3 = (e == 0) ? 1 : (e == 1) ? 0 : 2;
      wr(3'd1, 8'((a2 << 4) | a1)); wr(3'd2, 8'(a3));
      mx = d12(a1);
      if (d12(a2) > mx) mx = d12(a2);
      if (d3(a3) > mx) mx = d3(a3);
      send(3001);
      episode(mx * DIV + 20, c5, c6, c7);
      chk_win($sformatf("R3 R6 T1 code %0d", a1), c5, d12(a1));
      chk_win($sformatf("R4 R6 T2 code %0d", a2), c6, d12(a2));
      chk_win($sformatf("R5 R6 T3 code %0d", a3), c7, d3(a3));
      rd(3'd5, d); chk("R4 status all actions", d, 8'hFF);
      chk("R4 outputs", int'({aud, vib, soc, sys, cam, shut, irq}), 7'h7F);
      if (e == 2) begin
        send(0);
        wr(3'd4, 8'h88);
        chk("R10 disabled outputs low", int'({aud, vib, soc, sys, cam, shut}), 0);
        chk("R10 irq follows status", int'(irq), 1);
        wr(3'd4, 8'h08);
        chk("R10 re-enabled outputs", int'({aud, vib, soc, sys, cam, shut}), 6'h3F);
      end
      quiesce();
      chk("R8 cleared irq", int'(irq), 0);
    end

    // R4 system burst action needs cfg bit 3
    wr(3'd4, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h02);
    send(3001);
    episode(d12(0) * DIV + 20, c5, c6, c7);
    rd(3'd5, d); chk("R4 sys action gated", d, 8'h77);
    chk("R4 sys output low", int'(sys), 0);
    quiesce();
    wr(3'd4, 8'h08);

    // R9 mask zero
    wr(3'd3, 8'h00);
    send(3001);
    episode(d12(0) * DIV + 20, c5, c6, c7);
    rd(3'd5, d); chk("R9 masked status", d, 8'h60);
    chk("R9 masked outputs", int'({aud, vib, soc, sys, cam}), 0);
    send(0);

    // R8 write-back
    wr(3'd5, 8'hFF); rd(3'd5, d); chk("R8 write ones keeps", d, 8'h60);
    wr(3'd5, 8'h40); rd(3'd5, d); chk("R8 clear bit 5", d, 8'h40);
    chk("R8 irq on bit 6", int'(irq), 1);
    wr(3'd5, 8'h00); rd(3'd5, d); chk("R8 clear all", d, 0);
    chk("R8 irq low", int'(irq), 0);
    wr(3'd3, 8'h1F);

    // R7 timer restart
    send(3001);
    episode(500, c5, c6, c7);
    chk("R7 no early flag", c5, 0);
    send(3000);
    repeat (10) @(negedge clk);
    send(3001);
    episode(d12(0) * DIV + 20, c5, c6, c7);
    chk_win("R7 full duration after restart", c5, d12(0));
    quiesce();

    // R10 disabled unit
    wr(3'd4, 8'h88); rd(3'd4, d); chk("R10 cfg readback", d, 8'h88);
    send(5801);
    chk("R10 no shutdown when disabled", int'(shut), 0);
    episode(1000, c5, c6, c7);
    chk("R10 no T1 when disabled", c5, 0);
    rd(3'd5, d); chk("R10 no status when disabled", d, 0);
    send(0);
    wr(3'd4, 8'h08);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule